// File: doc/BRIEF.md
# Four-Channel Down-Counting Timer

This block is a bus-mapped timer with four independent down-counters. Software reaches it through a plain register port: address, write data, write strobe and combinational read data. Each channel holds a counter, a load value, a control byte and a background reload value. The timer tick arrives as a one-cycle enable in the bus clock domain and is divided per channel by 1, 16 or 256. Once a channel is enabled it decrements on every divided tick.

A channel runs in one of three modes. In free-running mode it wraps from zero to all-ones. In periodic mode it wraps from zero to its background value, which software may change at any time without disturbing the count in progress. In one-shot mode it stops at zero. A count that steps from one to zero raises that channel's raw interrupt flag. A shared mask selects which raw flags drive the single interrupt line, and a write-one-to-clear register drops flags. Software that wants a rising timebase reads the counter and negates or inverts it.

Top module: `quad_down_timer`

## Requirements
- R1: After reset every register reads zero and `irq` is low.
- R2: An enabled channel (control bit 7 = 1) moves one count per divided tick. A disabled channel holds its value while ticks arrive.
- R3: Control bits 3:2 set the tick divider: 00 passes every tick, 01 takes every 16th tick, 10 and 11 take every 256th. Any write to a channel's control register restarts that channel's divider count, so the first step comes after a full divided period.
- R4: In free-running mode (bit 6 = 0, bit 0 = 0), a step at zero gives all-ones across the active width.
- R5: In periodic mode (bit 6 = 1, bit 0 = 0), a step at zero reloads the background value, masked to the active width.
- R6: In one-shot mode (bit 0 = 1, whatever bit 6 holds), the counter stays at zero until software reloads it.
- R7: A step that takes channel n from 1 to 0 sets raw status bit n in every mode. Loading zero therefore raises no flag.
- R8: A write to a channel's load register replaces the count at once and also copies the value into the background register. A write to the background register alone leaves the running count untouched.
- R9: When control bit 1 is 0, only the low 16 bits count and wrap, and the value register reads zero in bits 31:16.
- R10: The map is word-aligned and byte-addressed. 0x00 is the mask, 0x04 raw status, 0x08 masked status and 0x0C clear. Channel n occupies 0x10+0x10*n, with load at +0x0, value at +0x4, control at +0x8 and background at +0xC. Accesses with address bits 1:0 nonzero do nothing and read zero.
- R11: Masked status is raw AND mask, and `irq` is high exactly when some masked bit is set.
- R12: Writing 1 to clear bit n drops raw bit n. Zero bits in a clear write, and any writes to the raw or masked status offsets, leave the flags unchanged.
- R13: The control register reads back bits 7, 6, 3, 2, 1 and 0 as written, with bits 5:4 and 31:8 reading zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | One-cycle timer tick enable |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Combinational read data for `bus_addr` |
| irq | output | 1 | OR of all masked interrupt flags |

## Verification
The embedded assertions allow tick pulses and bus writes in the same cycle. Where a control write and a counting step collide, they tolerate the configuration change rather than predict the result. They also take the address to select at most one register per cycle, so a load write never meets a background write on the same channel. The bench keeps bus writes and tick pulses in separate cycles, so every expected value depends only on the count of divided ticks since the last write. It sweeps each channel through every mode, both widths and a set of load values, which includes zero, one and a value with nonzero upper bits.

// File: rtl/qdt_pkg.sv
// qdt_pkg: shared constants and helpers for the four-channel timer.
// Assumes byte addressing with 32-bit word registers.
package qdt_pkg;

    // Control byte bit positions (software-visible, behaviour depends on them)
    localparam int CTL_EN      = 7;
    localparam int CTL_PERIOD  = 6;
    localparam int CTL_DIV_HI  = 3;
    localparam int CTL_DIV_LO  = 2;
    localparam int CTL_WIDE    = 1;
    localparam int CTL_SINGLE  = 0;

    // Bits kept in the control register; the rest read zero
    localparam logic [7:0] CTL_KEEP = 8'hCF;

    // Word index within a 16-byte slot
    localparam logic [1:0] SH_MASK   = 2'd0;
    localparam logic [1:0] SH_RAW    = 2'd1;
    localparam logic [1:0] SH_MSKD   = 2'd2;
    localparam logic [1:0] SH_CLR    = 2'd3;
    localparam logic [1:0] CH_LOAD   = 2'd0;
    localparam logic [1:0] CH_VALUE  = 2'd1;
    localparam logic [1:0] CH_CTRL   = 2'd2;
    localparam logic [1:0] CH_BG     = 2'd3;

    typedef enum logic [1:0] {
        RUN_FREE     = 2'd0,
        RUN_PERIODIC = 2'd1,
        RUN_SINGLE   = 2'd2
    } run_mode_e;

    // One-shot wins over periodic; neither bit set means free-running
    function automatic run_mode_e decode_mode(input logic [7:0] ctl);
        if (ctl[CTL_SINGLE])      return RUN_SINGLE;
        else if (ctl[CTL_PERIOD]) return RUN_PERIODIC;
        else                      return RUN_FREE;
    endfunction

endpackage

// File: rtl/qdt_prescaler.sv
// qdt_prescaler: divides the shared tick enable for one channel.
// Emits a one-cycle step on every 1st, 2**MID_LOG2-th or 2**HI_LOG2-th tick
// as selected by div_sel (00, 01, 1x). Assumes div_sel changes only together
// with a restart pulse, which clears the running count.
module qdt_prescaler #(
    parameter int MID_LOG2 = 4,
    parameter int HI_LOG2  = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  logic       tick_en,
    input  logic       restart,
    input  logic [1:0] div_sel,
    output logic       step
);
    localparam int CNT_W = HI_LOG2;
    localparam logic [CNT_W-1:0] LIM_MID = CNT_W'((1 << MID_LOG2) - 1);
    localparam logic [CNT_W-1:0] LIM_HI  = CNT_W'((1 << HI_LOG2) - 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;

    // Terminal count for the selected divide ratio
    always_comb begin
        case (div_sel)
            2'b00:   limit = '0;
            2'b01:   limit = LIM_MID;
            default: limit = LIM_HI;
        endcase
    end

    assign step = enable && tick_en && (cnt_q == limit);

    // Tick counter, cleared on reset, restart or while the channel is off
    always_ff @(posedge clk) begin
        if (!rst_n || restart || !enable) begin
            cnt_q <= '0;
        end else if (tick_en) begin
            cnt_q <= (cnt_q == limit) ? '0 : cnt_q + 1'b1;
        end
    end

    // The divider count never passes the terminal value of the current ratio
    assert_div_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= limit)
        else $error("prescaler count beyond limit");

endmodule

// File: rtl/qdt_channel.sv
// qdt_channel: one down-counter with load, background and width control.
// Counts on each 'step'; a load write takes priority over a step in the same
// cycle. Assumes load and background writes never coincide.
module qdt_channel
    import qdt_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int NARROW_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  run_mode_e         mode,
    input  logic              wide,
    input  logic              step,
    input  logic              load_wr,
    input  logic              bg_wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] value_rd,
    output logic [DATA_W-1:0] load_rd,
    output logic [DATA_W-1:0] bg_rd,
    output logic              zero_evt
);
    localparam logic [DATA_W-1:0] NARROW_MASK =
        {{(DATA_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

    logic [DATA_W-1:0] cnt_q, load_q, bg_q;
    logic [DATA_W-1:0] wmask, eff, cnt_next;

    assign wmask    = wide ? '1 : NARROW_MASK;
    assign eff      = cnt_q & wmask;
    assign value_rd = eff;
    assign load_rd  = load_q;
    assign bg_rd    = bg_q;
    assign zero_evt = step && !load_wr && (eff == DATA_W'(1));

    // Count after one step: decrement, or wrap according to the mode
    always_comb begin
        if (eff != '0) begin
            cnt_next = eff - 1'b1;
        end else begin
            case (mode)
                RUN_SINGLE:   cnt_next = '0;
                RUN_PERIODIC: cnt_next = bg_q & wmask;
                default:      cnt_next = wmask;
            endcase
        end
    end

    // Counter, load and background registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            load_q <= '0;
            bg_q   <= '0;
        end else begin
            if (load_wr) begin
                cnt_q  <= wdata;
                load_q <= wdata;
                bg_q   <= wdata;
            end else begin
                if (step)  cnt_q <= cnt_next;
                if (bg_wr) bg_q  <= wdata;
            end
        end
    end

    // A nonzero count moves down by exactly one per step
    assert_step_decrements_R2: assert property (@(posedge clk) disable iff (!rst_n)
        step && !load_wr && (eff != '0)
        |=> !$stable(wide) || (value_rd == DATA_W'($past(eff) - 1'b1)))
        else $error("count did not decrement");

    // Without a step or load the stored count stays put, background writes included
    assert_idle_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !step && !load_wr |=> $stable(cnt_q))
        else $error("count changed without step or load");

    // A one-shot channel resting at zero stays there
    assert_single_rests_R6: assert property (@(posedge clk) disable iff (!rst_n)
        step && !load_wr && (mode == RUN_SINGLE) && (eff == '0) |=> (cnt_q == '0))
        else $error("one-shot left zero");

    // A free-running channel at zero wraps to all-ones of its width
    assert_free_wraps_R4: assert property (@(posedge clk) disable iff (!rst_n)
        step && !load_wr && (mode == RUN_FREE) && (eff == '0)
        |=> !$stable(wide) || (value_rd == wmask))
        else $error("free-running wrap wrong");

    // A load write is visible as the new count on the next cycle
    assert_load_applies_R8: assert property (@(posedge clk) disable iff (!rst_n)
        load_wr |=> (cnt_q == $past(wdata)))
        else $error("load not applied");

endmodule

// File: rtl/qdt_irq_ctrl.sv
// qdt_irq_ctrl: raw flags, mask and combined interrupt for all channels.
// A new zero event in the same cycle as a clear of that bit wins, so no
// event is lost. Assumes zero_evt pulses last one cycle.
module qdt_irq_ctrl #(
    parameter int NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] zero_evt,
    input  logic              mask_wr,
    input  logic              clr_wr,
    input  logic [NUM_CH-1:0] wdata,
    output logic [NUM_CH-1:0] mask_q,
    output logic [NUM_CH-1:0] raw_q,
    output logic [NUM_CH-1:0] masked,
    output logic              irq
);
    logic [NUM_CH-1:0] clr_bits;

    assign clr_bits = clr_wr ? wdata : '0;
    assign masked   = raw_q & mask_q;
    assign irq      = |masked;

    // Mask register and raw flag register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
            raw_q  <= '0;
        end else begin
            if (mask_wr) mask_q <= wdata;
            raw_q <= (raw_q & ~clr_bits) | zero_evt;
        end
    end

    // Every zero event leaves its raw flag set
    assert_event_sets_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (|zero_evt) |=> ((raw_q & $past(zero_evt)) == $past(zero_evt)))
        else $error("zero event lost");

    // Cleared bits without a fresh event read zero afterwards
    assert_clear_drops_R12: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr |=> ((raw_q & $past(wdata & ~zero_evt)) == '0))
        else $error("clear did not drop flag");

    // With nothing masked in, the interrupt line stays low
    assert_no_mask_no_irq_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |-> !irq)
        else $error("irq with empty mask");

endmodule

// File: rtl/quad_down_timer.sv
// quad_down_timer: four down-counting channels behind a word register port.
// Slot 0 (0x00-0x0C) holds the shared interrupt registers; slot n+1 holds
// channel n. Reads are combinational; writes take effect at the next edge.
// Assumes tick_en is a single-cycle enable synchronous to clk.
module quad_down_timer
    import qdt_pkg::*;
#(
    parameter int NUM_CH   = 4,
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 8,
    parameter int NARROW_W = 16,
    parameter int MID_LOG2 = 4,
    parameter int HI_LOG2  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    localparam int SLOT_W = ADDR_W - 4;

    logic [SLOT_W-1:0] slot;
    logic [1:0]        word;
    logic              aligned;
    logic              shared_hit;

    assign slot       = bus_addr[ADDR_W-1:4];
    assign word       = bus_addr[3:2];
    assign aligned    = (bus_addr[1:0] == 2'b00);
    assign shared_hit = aligned && (slot == '0);

    logic [7:0]        ctrl_q   [NUM_CH];
    logic [DATA_W-1:0] value_rd [NUM_CH];
    logic [DATA_W-1:0] load_rd  [NUM_CH];
    logic [DATA_W-1:0] bg_rd    [NUM_CH];
    logic [NUM_CH-1:0] zero_evt;
    logic [NUM_CH-1:0] mask_q, raw_q, masked;

    genvar c;
    generate
        for (c = 0; c < NUM_CH; c++) begin : g_ch
            logic ch_hit, ctrl_wr, load_wr, bg_wr, step;

            assign ch_hit  = aligned && (slot == SLOT_W'(c + 1));
            assign ctrl_wr = bus_wr && ch_hit && (word == CH_CTRL);
            assign load_wr = bus_wr && ch_hit && (word == CH_LOAD);
            assign bg_wr   = bus_wr && ch_hit && (word == CH_BG);

            // Control byte for this channel, unused bits forced to zero
            always_ff @(posedge clk) begin
                if (!rst_n)       ctrl_q[c] <= '0;
                else if (ctrl_wr) ctrl_q[c] <= bus_wdata[7:0] & CTL_KEEP;
            end

            qdt_prescaler #(
                .MID_LOG2 (MID_LOG2),
                .HI_LOG2  (HI_LOG2)
            ) u_div (
                .clk     (clk),
                .rst_n   (rst_n),
                .enable  (ctrl_q[c][CTL_EN]),
                .tick_en (tick_en),
                .restart (ctrl_wr),
                .div_sel (ctrl_q[c][CTL_DIV_HI:CTL_DIV_LO]),
                .step    (step)
            );

            qdt_channel #(
                .DATA_W   (DATA_W),
                .NARROW_W (NARROW_W)
            ) u_cnt (
                .clk      (clk),
                .rst_n    (rst_n),
                .mode     (decode_mode(ctrl_q[c])),
                .wide     (ctrl_q[c][CTL_WIDE]),
                .step     (step),
                .load_wr  (load_wr),
                .bg_wr    (bg_wr),
                .wdata    (bus_wdata),
                .value_rd (value_rd[c]),
                .load_rd  (load_rd[c]),
                .bg_rd    (bg_rd[c]),
                .zero_evt (zero_evt[c])
            );

            // A disabled channel never produces a counting step
            assert_off_no_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
                !ctrl_q[c][CTL_EN] |-> !step)
                else $error("step while disabled");
        end
    endgenerate

    qdt_irq_ctrl #(
        .NUM_CH (NUM_CH)
    ) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .zero_evt (zero_evt),
        .mask_wr  (bus_wr && shared_hit && (word == SH_MASK)),
        .clr_wr   (bus_wr && shared_hit && (word == SH_CLR)),
        .wdata    (bus_wdata[NUM_CH-1:0]),
        .mask_q   (mask_q),
        .raw_q    (raw_q),
        .masked   (masked),
        .irq      (irq)
    );

    // Read multiplexer over the shared slot and every channel slot
    always_comb begin
        bus_rdata = '0;
        if (shared_hit) begin
            case (word)
                SH_MASK: bus_rdata = DATA_W'(mask_q);
                SH_RAW:  bus_rdata = DATA_W'(raw_q);
                SH_MSKD: bus_rdata = DATA_W'(masked);
                default: bus_rdata = '0;
            endcase
        end
        for (int i = 0; i < NUM_CH; i++) begin
            if (aligned && (slot == SLOT_W'(i + 1))) begin
                case (word)
                    CH_LOAD:  bus_rdata = load_rd[i];
                    CH_VALUE: bus_rdata = value_rd[i];
                    CH_CTRL:  bus_rdata = DATA_W'(ctrl_q[i]);
                    default:  bus_rdata = bg_rd[i];
                endcase
            end
        end
    end

    // The interrupt line only rises when some flag is masked in
    assert_irq_needs_mask_R11: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((raw_q & mask_q) != '0))
        else $error("irq without masked flag");

endmodule

// File: tb/quad_down_timer_bench.sv
// Sweeps every channel through all modes, widths and several load values,
// then probes dividers, interrupt registers and reset state.
module quad_down_timer_bench;
    localparam int NUM_CH = 4;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              tick_en = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_wr = 1'b0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic              irq;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    quad_down_timer #(
        .NUM_CH (NUM_CH),
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_quad_down_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    function automatic logic [7:0] ch_off(input int ch, input int w);
        return 8'(16 + 16 * ch + 4 * w);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick_en = 1'b1;
            @(negedge clk); tick_en = 1'b0;
        end
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    // Reference next count from R4-R6 and R9
    function automatic logic [31:0] ref_next(input logic [31:0] v, input int mode,
                                             input bit wide, input logic [31:0] bg);
        logic [31:0] m;
        m = wide ? 32'hFFFF_FFFF : 32'h0000_FFFF;
        if (v != 0)         return v - 1;
        else if (mode == 2) return 32'h0;
        else if (mode == 1) return bg & m;
        else                return m;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        n_vec++; n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_run();
    end

    initial begin
        logic [31:0] d, m, expv, bgm, ctl;
        logic [31:0] loads [4];
        bit flag;
        loads[0] = 32'h0; loads[1] = 32'h1; loads[2] = 32'h3; loads[3] = 32'h1234_0005;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state of every register and the interrupt line
        for (int a = 0; a < 80; a += 4) begin
            rd(8'(a), d);
            chk($sformatf("R1 reg@%0h", a), d, 32'h0);
        end
        chk("R1 irq", {31'h0, irq}, 32'h0);

        // R4 R5 R6 R7 R9 R13: sweep channel x mode x width x load
        for (int ch = 0; ch < NUM_CH; ch++) begin
            for (int mode = 0; mode < 3; mode++) begin
                for (int wide = 0; wide < 2; wide++) begin
                    for (int li = 0; li < 4; li++) begin
                        m   = wide ? 32'hFFFF_FFFF : 32'h0000_FFFF;
                        ctl = 32'h80 | (wide ? 32'h2 : 32'h0) |
                              (mode == 1 ? 32'h40 : 32'h0) | (mode == 2 ? 32'h41 : 32'h0);
                        wr(ch_off(ch, 2), 32'h0);
                        wr(8'h0C, 32'hF);
                        wr(ch_off(ch, 0), loads[li]);
                        wr(ch_off(ch, 2), ctl);
                        rd(ch_off(ch, 2), d);
                        chk("R13 ctrl readback", d, ctl);
                        expv = loads[li] & m;
                        bgm  = loads[li];
                        flag = 1'b0;
                        rd(ch_off(ch, 1), d);
                        chk("R9 initial value", d, expv);
                        for (int k = 1; k < 10; k++) begin
                            tick(1);
                            if (expv == 1) flag = 1'b1;
                            expv = ref_next(expv, mode, wide != 0, bgm);
                            rd(ch_off(ch, 1), d);
                            chk($sformatf("R5 ch%0d mode%0d wide%0d load%0d step%0d",
                                          ch, mode, wide, li, k), d, expv);
                            if (k == 2) begin
                                // R8: background write leaves the count alone
                                wr(ch_off(ch, 3), 32'h4);
                                bgm = 32'h4;
                                rd(ch_off(ch, 1), d);
                                chk("R8 background write no disturb", d, expv);
                            end
                        end
                        rd(8'h04, d);
                        chk($sformatf("R7 raw flag ch%0d mode%0d load%0d", ch, mode, li),
                            d, flag ? (32'h1 << ch) : 32'h0);
                        wr(ch_off(ch, 2), 32'h0);
                    end
                end
            end
        end

        // R2: disabled channel ignores ticks
        wr(ch_off(0, 0), 32'd50);
        wr(ch_off(0, 2), 32'h02);
        tick(5);
        rd(ch_off(0, 1), d);
        chk("R2 disabled holds", d, 32'd50);

        // R3: divide by 16
        wr(ch_off(0, 0), 32'd1000);
        wr(ch_off(0, 2), 32'h86);
        tick(47);
        rd(ch_off(0, 1), d);
        chk("R3 div16 after 47", d, 32'd998);
        tick(1);
        rd(ch_off(0, 1), d);
        chk("R3 div16 after 48", d, 32'd997);
        // R3: divide by 256 with code 10, restarted by the control write
        wr(ch_off(0, 0), 32'd1000);
        wr(ch_off(0, 2), 32'h8A);
        tick(255);
        rd(ch_off(0, 1), d);
        chk("R3 div256 after 255", d, 32'd1000);
        tick(1);
        rd(ch_off(0, 1), d);
        chk("R3 div256 after 256", d, 32'd999);
        // R3: code 11 also divides by 256
        wr(ch_off(0, 0), 32'd1000);
        wr(ch_off(0, 2), 32'h8E);
        tick(256);
        rd(ch_off(0, 1), d);
        chk("R3 code11 after 256", d, 32'd999);
        wr(ch_off(0, 2), 32'h0);

        // R8: load while running applies at once and copies to background
        wr(ch_off(1, 0), 32'd100);
        wr(ch_off(1, 2), 32'h82);
        tick(3);
        rd(ch_off(1, 1), d);
        chk("R2 running count", d, 32'd97);
        wr(ch_off(1, 0), 32'd20);
        rd(ch_off(1, 1), d);
        chk("R8 immediate load", d, 32'd20);
        rd(ch_off(1, 3), d);
        chk("R8 load copies background", d, 32'd20);
        wr(ch_off(1, 2), 32'h0);

        // R10: unaligned access neither writes nor reads
        wr(ch_off(2, 0) | 8'h1, 32'd77);
        rd(ch_off(2, 0), d);
        chk("R10 unaligned write ignored", d, 32'h1234_0005);
        rd(ch_off(2, 0) | 8'h2, d);
        chk("R10 unaligned read zero", d, 32'h0);

        // R11 R12: interrupt path on channel 2, one-shot from 2
        wr(8'h0C, 32'hF);
        wr(ch_off(2, 0), 32'd2);
        wr(ch_off(2, 2), 32'h83);
        tick(3);
        rd(8'h04, d);
        chk("R7 one-shot flag", d, 32'h4);
        rd(ch_off(2, 1), d);
        chk("R6 one-shot rests", d, 32'h0);
        chk("R11 irq masked off", {31'h0, irq}, 32'h0);
        wr(8'h00, 32'h4);
        rd(8'h08, d);
        chk("R11 masked status", d, 32'h4);
        chk("R11 irq on", {31'h0, irq}, 32'h1);
        wr(8'h00, 32'hB);
        rd(8'h08, d);
        chk("R11 masked other bits", d, 32'h0);
        chk("R11 irq off", {31'h0, irq}, 32'h0);
        wr(8'h00, 32'h4);
        wr(8'h04, 32'h0);
        wr(8'h08, 32'h0);
        wr(8'h0C, 32'hB);
        rd(8'h04, d);
        chk("R12 flag kept", d, 32'h4);
        wr(8'h0C, 32'h4);
        rd(8'h04, d);
        chk("R12 flag cleared", d, 32'h0);
        chk("R12 irq after clear", {31'h0, irq}, 32'h0);

        finish_run();
    end
endmodule